// File: doc/BRIEF.md
# Four-Entry Master Data Buffer

This block is a small byte staging store that sits between a processor's register port and a serial-bus master engine. The processor pushes bytes with single-cycle write strobes and pops the oldest byte with read strobes; a read of an empty store returns all ones. Two flag outputs tell the rest of the controller whether the store holds anything and whether it is full.

The transfer engine has its own side door. It can read any entry by index while it sends bytes out. After a receive it can load a batch of bytes and set the fill level in one cycle. A flush strobe clears everything at once. The register decode, the bus engine and the interrupt logic sit outside this block and drive its strobes.

Top module: `mbuf_stage`

## Requirements
- R1: The store holds N=4 entries of W=8 bits. The `fill` output gives the number of valid bytes, from 0 (empty) to 4 (full). Entry 0 is the oldest.
- R2: A processor write while `fill` is 4, with no read in the same cycle, is ignored. The fill level, the flags and all entries stay as they were.
- R3: A write stores its byte in the entry whose index equals the fill level after any read in that cycle, then adds one to the fill level. A write that takes the fill level to 1 raises `not_empty`. A write that takes it to 4 raises `full`.
- R4: While `fill` is 0, `cpu_rdata` shows 0xFF. A read strobe at that level changes no state.
- R5: While `fill` is non-zero, `cpu_rdata` shows entry 0. A read strobe moves entries 1..3 down to 0..2, leaves entry 3 unchanged and lowers the fill level by one.
- R6: A read taken at fill level 4 lowers `full`. A read taken at fill level 1 lowers `not_empty`.
- R7: A flush strobe zeroes all four entries, sets the fill level to 0 and lowers both flags in the next cycle.
- R8: An engine load with count N writes byte i of `eng_data` (bits 8i+7..8i) into entry i for every i < N. Entries at i >= N keep their values. The fill level becomes N. `not_empty` is set when N >= 1 and `full` is set when N = 4. Counts above 4 act as 4.
- R9: `eng_rdata` shows entry `eng_idx` at all times, whatever the fill level.
- R10: Asynchronous active-low reset zeroes all entries, sets the fill level to 0 and lowers both flags.
- R11: A read and a write in the same cycle act as the read followed by the write. At fill level 4 the oldest byte leaves, the new byte enters entry 3, and the level stays at 4.
- R12: Flush has priority over engine load, and engine load has priority over processor reads and writes. A lower-priority strobe in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | Processor push strobe |
| cpu_wdata | input | 8 | Byte to push |
| cpu_rd | input | 1 | Processor pop strobe |
| cpu_rdata | output | 8 | Oldest byte, or 0xFF when empty |
| flush | input | 1 | Clear-all strobe |
| eng_load | input | 1 | Engine batch-load strobe |
| eng_count | input | 3 | Number of bytes in the batch |
| eng_data | input | 32 | Batch bytes, entry i in byte i |
| eng_idx | input | 2 | Entry index for engine read |
| eng_rdata | output | 8 | Entry selected by eng_idx |
| fill | output | 3 | Number of valid bytes |
| not_empty | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |

## Verification
A processor pop and a processor push can land in the same cycle. The most telling cases are at fill level 0, where the pop does nothing and the push makes the level 1, and at fill level 4, where both take effect and `full` has to stay high. The bench drives these pairs on purpose. It also drives them inside a long pseudo-random strobe sequence that includes flushes and engine loads in the same cycle. After every cycle it checks the read data, the level, both flags and all four entries against an arithmetic model that applies the pop before the push.

// File: rtl/mbuf_stage.sv
module mbuf_stage #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_wr,
  input  logic [W-1:0]             cpu_wdata,
  input  logic                     cpu_rd,
  output logic [W-1:0]             cpu_rdata,
  input  logic                     flush,
  input  logic                     eng_load,
  input  logic [$clog2(N+1)-1:0]   eng_count,
  input  logic [N*W-1:0]           eng_data,
  input  logic [$clog2(N)-1:0]     eng_idx,
  output logic [W-1:0]             eng_rdata,
  output logic [$clog2(N+1)-1:0]   fill,
  output logic                     not_empty,
  output logic                     full
);
  localparam int CW = $clog2(N+1);
  localparam int IW = $clog2(N);

  logic [W-1:0]  mem [N];
  logic [W-1:0]  nxt [N];
  logic [CW-1:0] cnt, cnt_n, ld;
  logic          ne_q, fu_q, ne_n, fu_n;

  assign ld        = (eng_count > CW'(N)) ? CW'(N) : eng_count;
  assign cpu_rdata = (cnt == '0) ? {W{1'b1}} : mem[0];
  assign eng_rdata = mem[eng_idx];
  assign fill      = cnt;
  assign not_empty = ne_q;
  assign full      = fu_q;

  always_comb begin
    nxt   = mem;
    cnt_n = cnt;
    ne_n  = ne_q;
    fu_n  = fu_q;
    if (flush) begin
      for (int i = 0; i < N; i++) nxt[i] = '0;
      cnt_n = '0;
      ne_n  = 1'b0;
      fu_n  = 1'b0;
    end else if (eng_load) begin
      for (int i = 0; i < N; i++)
        if (CW'(i) < ld) nxt[i] = eng_data[i*W +: W];
      cnt_n = ld;
      ne_n  = (ld != '0);
      fu_n  = (ld == CW'(N));
    end else begin
      if (cpu_rd && cnt != '0) begin
        for (int i = 0; i < N-1; i++) nxt[i] = mem[i+1];
        if (cnt == CW'(N)) fu_n = 1'b0;
        if (cnt == CW'(1)) ne_n = 1'b0;
        cnt_n = cnt - CW'(1);
      end
      if (cpu_wr && cnt_n != CW'(N)) begin
        nxt[cnt_n[IW-1:0]] = cpu_wdata;
        if (cnt_n == '0) ne_n = 1'b1;
        if (cnt_n == CW'(N-1)) fu_n = 1'b1;
        cnt_n = cnt_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
      cnt  <= '0;
      ne_q <= 1'b0;
      fu_q <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) mem[i] <= nxt[i];
      cnt  <= cnt_n;
      ne_q <= ne_n;
      fu_q <= fu_n;
    end
  end
endmodule

// File: rtl/mbuf_stage_chk.sv
module mbuf_stage_chk #(
  parameter int W = 8,
  parameter int N = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_wr,
  input logic                   cpu_rd,
  input logic [W-1:0]           cpu_rdata,
  input logic                   flush,
  input logic                   eng_load,
  input logic [$clog2(N+1)-1:0] eng_count,
  input logic [$clog2(N+1)-1:0] fill,
  input logic                   not_empty,
  input logic                   full
);
  localparam int CW = $clog2(N+1);

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(N));

  assert_flags_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty == (fill != '0)) && (full == (fill == CW'(N))));

  assert_full_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cpu_wr && !cpu_rd && !flush && !eng_load) |=> (full && $stable(fill)));

  assert_empty_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> (cpu_rdata == {W{1'b1}}));

  assert_empty_read_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill == '0) && cpu_rd && !cpu_wr && !flush && !eng_load) |=> (fill == '0));

  assert_last_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill == CW'(1)) && cpu_rd && !cpu_wr && !flush && !eng_load) |=> !not_empty);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((fill == '0) && !not_empty && !full));

  assert_load_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_load && !flush && eng_count >= CW'(N)) |=> full);

  assert_swap_keeps_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cpu_wr && cpu_rd && !flush && !eng_load) |=> full);
endmodule

bind mbuf_stage mbuf_stage_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_rdata(cpu_rdata), .flush(flush), .eng_load(eng_load),
  .eng_count(eng_count), .fill(fill), .not_empty(not_empty), .full(full)
);

// File: tb/mbuf_stage_test.sv
`timescale 1ns/1ps
module mbuf_stage_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_wr = 0, cpu_rd = 0, flush = 0, eng_load = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [2:0]  eng_count = 0;
  logic [31:0] eng_data = 0;
  logic [1:0]  eng_idx = 0;
  logic [7:0]  cpu_rdata, eng_rdata;
  logic [2:0]  fill;
  logic        not_empty, full;

  int nchk = 0, nfail = 0, cyc = 0;
  int m[4];
  int c = 0;

  always #10 clk = ~clk;

  mbuf_stage uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk({tag, " R1 fill"}, int'(fill), c);
    chk({tag, " R3 not_empty"}, int'(not_empty), int'(c != 0));
    chk({tag, " R6 full"}, int'(full), int'(c == 4));
    for (int i = 0; i < 4; i++) begin
      eng_idx = 2'(i);
      #1;
      chk({tag, " R9 entry"}, int'(eng_rdata), m[i]);
    end
    chk({tag, c == 0 ? " R4 rdata" : " R5 rdata"}, int'(cpu_rdata), c == 0 ? 'hFF : m[0]);
  endtask

  task automatic step(string tag, bit wr, bit rd, bit fl, bit ld, int wd, int ec, logic [31:0] ed);
    int n;
    cpu_wr = wr; cpu_rd = rd; flush = fl; eng_load = ld;
    cpu_wdata = 8'(wd); eng_count = 3'(ec); eng_data = ed;
    if (fl) begin
      for (int i = 0; i < 4; i++) m[i] = 0;
      c = 0;
    end else if (ld) begin
      n = (ec > 4) ? 4 : ec;
      for (int i = 0; i < n; i++) m[i] = int'(ed[i*8 +: 8]);
      c = n;
    end else begin
      if (rd && c > 0) begin
        for (int i = 0; i < 3; i++) m[i] = m[i+1];
        c--;
      end
      if (wr && c < 4) begin
        m[c] = wd;
        c++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; flush = 0; eng_load = 0;
    check_state(tag);
  endtask

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) m[i] = 0;
    #5;
    check_state("R10 reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    step("R4 empty read", 0, 1, 0, 0, 0, 0, 0);
    step("R3 first write", 1, 0, 0, 0, 'h11, 0, 0);
    step("R3 write", 1, 0, 0, 0, 'h22, 0, 0);
    step("R3 write", 1, 0, 0, 0, 'h33, 0, 0);
    step("R3 full write", 1, 0, 0, 0, 'h44, 0, 0);
    step("R2 write when full", 1, 0, 0, 0, 'h55, 0, 0);
    step("R11 swap at full", 1, 1, 0, 0, 'h66, 0, 0);
    step("R6 read at full", 0, 1, 0, 0, 0, 0, 0);
    step("R5 read", 0, 1, 0, 0, 0, 0, 0);
    step("R5 read", 0, 1, 0, 0, 0, 0, 0);
    step("R6 last read", 0, 1, 0, 0, 0, 0, 0);
    step("R11 swap at empty", 1, 1, 0, 0, 'h77, 0, 0);
    step("R8 load 3", 0, 0, 0, 1, 0, 3, 32'hA4A3A2A1);
    step("R8 load 4", 0, 0, 0, 1, 0, 4, 32'hB4B3B2B1);
    step("R8 load 0", 0, 0, 0, 1, 0, 0, 32'hC4C3C2C1);
    step("R8 load 7", 0, 0, 0, 1, 0, 7, 32'hD4D3D2D1);
    step("R12 load beats cpu", 1, 1, 0, 1, 'h99, 2, 32'hE4E3E2E1);
    step("R12 flush beats load", 1, 0, 1, 1, 'h99, 4, 32'hF4F3F2F1);
    step("R7 flush", 0, 0, 1, 0, 0, 0, 0);

    lf = 16'hACE1;
    for (int k = 0; k < 6000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R11 sweep", lf[0] | lf[1], lf[2] & lf[3] | lf[9], (lf[7:4] == 4'hF),
           (lf[11:8] == 4'h3), int'(lf[15:8]), int'(lf[14:12]),
           {lf, lf[7:0], lf[15:8]} ^ 32'(k));
    end

    step("R3 fill", 1, 0, 0, 0, 'h5A, 0, 0);
    #3; rst_n = 0; #2;
    for (int i = 0; i < 4; i++) m[i] = 0;
    c = 0;
    check_state("R10 mid reset");
    @(negedge clk); rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule